// File: doc/BRIEF.md
# TMDS Lane Test Pattern Generator

This block sits directly in front of a 10-bit-per-character serialiser. Each clock it produces one data-lane word and one clock-lane word. The data-lane word comes from one of four sources: the normally encoded character, constant zero, a pseudo-random bit sequence, or a user-programmed sequence of eight 10-bit words. The clock-lane word comes from a 40-bit pattern register that software loads and can optionally rotate one 10-bit field per cycle. Rotation is used when the link clock runs at a quarter of the character rate.

Configuration arrives as static register contents:
- a control word with the source select, the PRBS controls and the shift-pattern controls;
- three words that hold the eight shift-pattern characters;
- two words that hold the four clock-lane fields;
- a two-bit clock-pattern command.

The pseudo-random generator offers four polynomials. Each cycle it can deliver 1, 8 or 10 fresh bits.

Top module: `tmds_pattern_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `dataOut` and `clkOut` are zero, and the PRBS state is all ones.
- R2: `cfgWord[14:12]` selects the data source, seen on `dataOut` one clock after the edge that samples it. The codes are: 001 gives `normData`, 010 gives the PRBS word, 100 gives the shift-pattern word, and 000 or any other code gives zero.
- R3: `cfgWord[4:3]` picks the PRBS polynomial: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. The generator is a left-shifting Fibonacci register; the new bit is the XOR of the two tap stages. When `cfgWord[0]` is 0, the PRBS word is zero and the state is reloaded with all ones. An all-zero state is also replaced by all ones.
- R4: `cfgWord[2:1]` sets the PRBS word width: 0 = idle, 1 = 8 bits, 2 = 1 bit, 3 = 10 bits. The first generated bit lands in bit 0. Unused upper bits are zero. In idle the state holds and the word is zero.
- R5: In 10-bit width the PRBS advances ten steps per cycle, and all ten generated bits appear in the output word.
- R6: Shift-pattern word k (k = 0..7) is bits `10*(k%3)+9 : 10*(k%3)` of `shiftPatA` (k = 0..2), of `shiftPatB` (k = 3..5) or of `shiftPatC` (k = 6..7). While `cfgWord[8]` is 1, the words are issued in order from 0 to 7 and then wrap to 0.
- R7: Each shift-pattern word is held for `cfgWord[11:9]` + 1 consecutive cycles (1 to 8).
- R8: While `cfgWord[8]` is 0, the word index and hold count return to 0 and the shift-pattern word is zero. On re-enable the sequence restarts at word 0.
- R9: `clkCtrl[0]` = 1 loads the clock pattern from four fields: field0 = `clkPatA[9:0]`, field1 = `clkPatA[25:16]`, field2 = `clkPatB[9:0]`, field3 = `clkPatB[25:16]`. On the next cycle `clkOut` shows field0.
- R10: `clkCtrl[1]` = 1 without load rotates the pattern by one field per cycle. `clkOut` then steps field0, field1, field2, field3, field0, and so on.
- R11: Load takes priority over rotate. With neither bit set, `clkOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rstN | input | 1 | Active-low synchronous reset |
| normData | input | 10 | Normally encoded character |
| cfgWord | input | 15 | Select, shift and PRBS control fields |
| shiftPatA | input | 30 | Shift-pattern words 0..2 |
| shiftPatB | input | 30 | Shift-pattern words 3..5 |
| shiftPatC | input | 20 | Shift-pattern words 6..7 |
| clkPatA | input | 26 | Clock-lane fields 0 and 1 |
| clkPatB | input | 26 | Clock-lane fields 2 and 3 |
| clkCtrl | input | 2 | Clock-pattern load (bit 0) and rotate (bit 1) |
| dataOut | output | 10 | Data-lane word to the serialiser |
| clkOut | output | 10 | Clock-lane word to the serialiser |

## Verification
The assertions check the following on every cycle:
- a zero select yields a zero word;
- narrow PRBS widths leave the upper bits clear;
- the shift index only steps by one or returns to zero, and clears whenever the shift generator is off;
- the clock-lane word is stable when neither load nor rotate is asserted.

Only the bench's reference model can show the actual bit sequences: each polynomial's output, the reseed after disable, the hold length per repeat value, the word order across the three pattern registers, and the field order of the rotating clock pattern. The model is compared against both outputs on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  parameter int TMDS_W      = 10;
  parameter int SHIFT_WORDS = 8;
  parameter int IDX_W       = $clog2(SHIFT_WORDS);
  parameter int REP_W       = 3;
  parameter int LFSR_W      = 31;
  parameter int CLK_FIELDS  = 4;
  parameter int CLK_PAT_W   = CLK_FIELDS * TMDS_W;
  parameter int CFG_W       = 15;
  parameter int PAT_REG_W   = 3 * TMDS_W;
  parameter int CLK_REG_W   = 26;
  parameter int CLK_HI_LSB  = 16;

  parameter int SEL_LSB = 12;
  parameter int REP_LSB = 9;
  parameter int SH_EN   = 8;
  parameter int MODE_LSB = 3;
  parameter int WID_LSB = 1;
  parameter int PRBS_EN = 0;

  typedef enum logic [2:0] {
    SEL_ZERO  = 3'b000,
    SEL_NORM  = 3'b001,
    SEL_PRBS  = 3'b010,
    SEL_SHIFT = 3'b100
  } outSel_e;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_BYTE = 2'd1,
    PW_BIT  = 2'd2,
    PW_WORD = 2'd3
  } prbsWidth_e;

  typedef enum logic [1:0] {
    PM_11 = 2'd0,
    PM_15 = 2'd1,
    PM_7  = 2'd2,
    PM_31 = 2'd3
  } prbsMode_e;

  typedef struct packed {
    outSel_e          outSel;
    logic             prbsRun;
    logic             prbsReseed;
    prbsWidth_e       prbsWidth;
    prbsMode_e        prbsMode;
    logic             shiftValid;
    logic [IDX_W-1:0] shiftIdx;
    logic             clkLoad;
    logic             clkRotate;
  } tpgStrobe_t;
endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [1:0]       clkCtrl,
  output tpgStrobe_t       strb
);
  logic [IDX_W-1:0] idxQ;
  logic [REP_W-1:0] holdCnt;
  logic [REP_W-1:0] repVal;
  logic             shiftEn;
  outSel_e          selDec;
  logic [2:0]       unusedCfg;

  assign unusedCfg = cfgWord[7:5];
  assign repVal    = cfgWord[REP_LSB +: REP_W];
  assign shiftEn   = cfgWord[SH_EN];

  always_comb begin
    case (cfgWord[SEL_LSB +: 3])
      3'b001:  selDec = SEL_NORM;
      3'b010:  selDec = SEL_PRBS;
      3'b100:  selDec = SEL_SHIFT;
      default: selDec = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !shiftEn) begin
      idxQ    <= '0;
      holdCnt <= '0;
    end else if (holdCnt >= repVal) begin
      holdCnt <= '0;
      idxQ    <= (idxQ == IDX_W'(SHIFT_WORDS - 1)) ? '0 : idxQ + 1'b1;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    strb.outSel     = selDec;
    strb.prbsRun    = cfgWord[PRBS_EN];
    strb.prbsReseed = !cfgWord[PRBS_EN];
    strb.prbsWidth  = prbsWidth_e'(cfgWord[WID_LSB +: 2]);
    strb.prbsMode   = prbsMode_e'(cfgWord[MODE_LSB +: 2]);
    strb.shiftValid = shiftEn;
    strb.shiftIdx   = idxQ;
    strb.clkLoad    = clkCtrl[0];
    strb.clkRotate  = clkCtrl[1];
  end

  // R8
  shift_idx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> idxQ == '0);

  // R6
  shift_idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ != $past(idxQ)) |-> ((idxQ == $past(idxQ) + 1'b1) || (idxQ == '0)));
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  tpgStrobe_t            strb,
  input  logic [TMDS_W-1:0]     normData,
  input  logic [PAT_REG_W-1:0]  shiftPatA,
  input  logic [PAT_REG_W-1:0]  shiftPatB,
  input  logic [2*TMDS_W-1:0]   shiftPatC,
  input  logic [CLK_REG_W-1:0]  clkPatA,
  input  logic [CLK_REG_W-1:0]  clkPatB,
  output logic [TMDS_W-1:0]     dataOut,
  output logic [TMDS_W-1:0]     clkOut
);
  localparam int FLAT_W = SHIFT_WORDS * TMDS_W;

  logic [FLAT_W-1:0]     shiftFlat;
  logic [TMDS_W-1:0]     shiftWords [SHIFT_WORDS];
  logic [TMDS_W-1:0]     shiftWord;
  logic [LFSR_W-1:0]     lfsrQ, lfsrNext;
  logic [TMDS_W-1:0]     prbsWord;
  logic [CLK_PAT_W-1:0]  clkShift, clkLoadVal;
  logic [11:0]           unusedClkBits;

  assign shiftFlat = {shiftPatC, shiftPatB, shiftPatA};
  assign unusedClkBits = {clkPatA[CLK_HI_LSB-1:TMDS_W], clkPatB[CLK_HI_LSB-1:TMDS_W]};

  for (genvar k = 0; k < SHIFT_WORDS; k++) begin : g_words
    assign shiftWords[k] = shiftFlat[k*TMDS_W +: TMDS_W];
  end

  assign shiftWord = strb.shiftValid ? shiftWords[strb.shiftIdx] : '0;

  function automatic logic feedback(input prbsMode_e m, input logic [LFSR_W-1:0] s);
    case (m)
      PM_7:    feedback = s[6]  ^ s[5];
      PM_11:   feedback = s[10] ^ s[8];
      PM_15:   feedback = s[14] ^ s[13];
      default: feedback = s[30] ^ s[27];
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lenMask(input prbsMode_e m);
    case (m)
      PM_7:    lenMask = LFSR_W'(32'h0000_007F);
      PM_11:   lenMask = LFSR_W'(32'h0000_07FF);
      PM_15:   lenMask = LFSR_W'(32'h0000_7FFF);
      default: lenMask = '1;
    endcase
  endfunction

  always_comb begin
    logic [LFSR_W-1:0] st;
    logic [TMDS_W-1:0] word;
    logic              fb;
    int                steps;
    case (strb.prbsWidth)
      PW_BYTE: steps = 8;
      PW_BIT:  steps = 1;
      PW_WORD: steps = TMDS_W;
      default: steps = 0;
    endcase
    st = lfsrQ;
    if ((st & lenMask(strb.prbsMode)) == '0) st = '1;
    word = '0;
    fb   = 1'b0;
    for (int i = 0; i < TMDS_W; i++) begin
      if (i < steps) begin
        fb      = feedback(strb.prbsMode, st);
        st      = {st[LFSR_W-2:0], fb};
        word[i] = fb;
      end
    end
    lfsrNext = st;
    prbsWord = strb.prbsRun ? word : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.prbsReseed) lfsrQ <= '1;
    else                          lfsrQ <= lfsrNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataOut <= '0;
    else begin
      case (strb.outSel)
        SEL_NORM:  dataOut <= normData;
        SEL_PRBS:  dataOut <= prbsWord;
        SEL_SHIFT: dataOut <= shiftWord;
        default:   dataOut <= '0;
      endcase
    end
  end

  assign clkLoadVal = {clkPatB[CLK_HI_LSB +: TMDS_W], clkPatB[TMDS_W-1:0],
                       clkPatA[CLK_HI_LSB +: TMDS_W], clkPatA[TMDS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN)               clkShift <= '0;
    else if (strb.clkLoad)   clkShift <= clkLoadVal;
    else if (strb.clkRotate) clkShift <= {clkShift[TMDS_W-1:0], clkShift[CLK_PAT_W-1:TMDS_W]};
  end

  assign clkOut = clkShift[TMDS_W-1:0];

  // R2
  zero_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.outSel == SEL_ZERO |=> dataOut == '0);

  // R4
  prbs_bit_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outSel == SEL_PRBS && strb.prbsWidth == PW_BIT) |=> dataOut[TMDS_W-1:1] == '0);

  // R4
  prbs_byte_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outSel == SEL_PRBS && strb.prbsWidth == PW_BYTE) |=> dataOut[TMDS_W-1:8] == '0);

  // R11
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clkLoad && !strb.clkRotate) |=> $stable(clkOut));
endmodule

// File: rtl/tmds_pattern_gen.sv
module tmds_pattern_gen
  import tpg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TMDS_W-1:0]    normData,
  input  logic [CFG_W-1:0]     cfgWord,
  input  logic [PAT_REG_W-1:0] shiftPatA,
  input  logic [PAT_REG_W-1:0] shiftPatB,
  input  logic [2*TMDS_W-1:0]  shiftPatC,
  input  logic [CLK_REG_W-1:0] clkPatA,
  input  logic [CLK_REG_W-1:0] clkPatB,
  input  logic [1:0]           clkCtrl,
  output logic [TMDS_W-1:0]    dataOut,
  output logic [TMDS_W-1:0]    clkOut
);
  tpgStrobe_t strb;

  tpg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWord (cfgWord),
    .clkCtrl (clkCtrl),
    .strb    (strb)
  );

  tpg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .normData  (normData),
    .shiftPatA (shiftPatA),
    .shiftPatB (shiftPatB),
    .shiftPatC (shiftPatC),
    .clkPatA   (clkPatA),
    .clkPatB   (clkPatB),
    .dataOut   (dataOut),
    .clkOut    (clkOut)
  );
endmodule

// File: tb/tmds_pattern_gen_tb.sv
module tmds_pattern_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  normData;
  logic [14:0] cfgWord;
  logic [29:0] shiftPatA, shiftPatB;
  logic [19:0] shiftPatC;
  logic [25:0] clkPatA, clkPatB;
  logic [1:0]  clkCtrl;
  logic [9:0]  dataOut, clkOut;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string curReq = "R1";

  logic [30:0] mLfsr;
  int          mIdx, mCnt;
  logic [39:0] mClk;
  logic [9:0]  expData, expClk;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmds_pattern_gen u_dut (
    .clk(clk), .rstN(rstN), .normData(normData), .cfgWord(cfgWord),
    .shiftPatA(shiftPatA), .shiftPatB(shiftPatB), .shiftPatC(shiftPatC),
    .clkPatA(clkPatA), .clkPatB(clkPatB), .clkCtrl(clkCtrl),
    .dataOut(dataOut), .clkOut(clkOut)
  );

  function automatic logic [14:0] mkCfg(input int sel, input int rep, input bit shEn,
                                        input int mode, input int width, input bit pEn);
    logic [14:0] c = '0;
    c[14:12] = 3'(sel); c[11:9] = 3'(rep); c[8] = shEn;
    c[4:3] = 2'(mode); c[2:1] = 2'(width); c[0] = pEn;
    return c;
  endfunction

  function automatic logic [9:0] patWord(input int k);
    logic [79:0] all = {shiftPatC, shiftPatB, shiftPatA};
    return all[k*10 +: 10];
  endfunction

  task automatic compare();
    checks++;
    if (dataOut !== expData) begin
      failures++;
      $display("FAIL %s dataOut actual=%h expected=%h", curReq, dataOut, expData);
    end
    checks++;
    if (clkOut !== expClk) begin
      failures++;
      $display("FAIL %s clkOut actual=%h expected=%h", curReq, clkOut, expClk);
    end
  endtask

  task automatic modelStep();
    int plen, ptap, n;
    logic [9:0] pw, sw;
    logic [39:0] ld;
    case (cfgWord[4:3])
      2'd0: begin plen = 11; ptap = 9;  end
      2'd1: begin plen = 15; ptap = 14; end
      2'd2: begin plen = 7;  ptap = 6;  end
      default: begin plen = 31; ptap = 28; end
    endcase
    case (cfgWord[2:1])
      2'd1: n = 8;
      2'd2: n = 1;
      2'd3: n = 10;
      default: n = 0;
    endcase
    pw = '0;
    if (cfgWord[0]) begin
      for (int b = 0; b < n; b++) begin
        logic nb = mLfsr[plen-1] ^ mLfsr[ptap-1];
        mLfsr = {mLfsr[29:0], nb};
        pw[b] = nb;
      end
    end else mLfsr = '1;
    sw = cfgWord[8] ? patWord(mIdx) : 10'd0;
    if (!cfgWord[8]) begin mIdx = 0; mCnt = 0; end
    else if (mCnt >= int'(cfgWord[11:9])) begin mCnt = 0; mIdx = (mIdx + 1) % 8; end
    else mCnt++;
    case (cfgWord[14:12])
      3'b001: expData = normData;
      3'b010: expData = pw;
      3'b100: expData = sw;
      default: expData = '0;
    endcase
    ld = {clkPatB[25:16], clkPatB[9:0], clkPatA[25:16], clkPatA[9:0]};
    if (clkCtrl[0]) mClk = ld;
    else if (clkCtrl[1]) mClk = {mClk[9:0], mClk[39:10]};
    expClk = mClk[9:0];
  endtask

  task automatic tick();
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      normData = 10'((i * 37 + 5) ^ (checks * 3));
      tick();
    end
  endtask

  initial begin
    rstN = 0; normData = '0; cfgWord = '0; clkCtrl = '0;
    shiftPatA = {10'h203, 10'h102, 10'h001};
    shiftPatB = {10'h306, 10'h0F5, 10'h2A4};
    shiftPatC = {10'h3C8, 10'h1B7};
    clkPatA = {10'h3E0, 6'h0, 10'h01F};
    clkPatB = {10'h0AA, 6'h0, 10'h155};
    mLfsr = '1; mIdx = 0; mCnt = 0; mClk = '0; expData = '0; expClk = '0;
    repeat (3) @(negedge clk);
    curReq = "R1"; compare();
    rstN = 1;
    curReq = "R1"; compare();

    curReq = "R2"; cfgWord = mkCfg(1, 0, 0, 0, 0, 0); run(6);
    curReq = "R2"; cfgWord = mkCfg(3, 0, 0, 0, 0, 0); run(3);
    curReq = "R2"; cfgWord = mkCfg(7, 0, 1, 0, 3, 1); run(3);
    curReq = "R2"; cfgWord = mkCfg(0, 0, 0, 0, 0, 0); run(2);

    curReq = "R3"; cfgWord = mkCfg(2, 0, 0, 2, 2, 1); run(20);
    curReq = "R4"; cfgWord = mkCfg(2, 0, 0, 0, 1, 1); run(12);
    curReq = "R4"; cfgWord = mkCfg(2, 0, 0, 0, 0, 1); run(4);
    curReq = "R5"; cfgWord = mkCfg(2, 0, 0, 2, 3, 1); run(15);
    curReq = "R5"; cfgWord = mkCfg(2, 0, 0, 1, 3, 1); run(15);
    curReq = "R3"; cfgWord = mkCfg(2, 0, 0, 3, 3, 1); run(15);
    curReq = "R3"; cfgWord = mkCfg(2, 0, 0, 3, 3, 0); run(2);
    curReq = "R3"; cfgWord = mkCfg(2, 0, 0, 3, 3, 1); run(6);
    curReq = "R3"; cfgWord = mkCfg(1, 0, 0, 1, 1, 1); run(4);
    curReq = "R3"; cfgWord = mkCfg(2, 0, 0, 1, 1, 1); run(4);

    curReq = "R6"; cfgWord = mkCfg(4, 0, 1, 0, 0, 0); run(19);
    curReq = "R7"; cfgWord = mkCfg(4, 2, 1, 0, 0, 0); run(26);
    curReq = "R7"; cfgWord = mkCfg(4, 7, 1, 0, 0, 0); run(20);
    curReq = "R8"; cfgWord = mkCfg(4, 7, 0, 0, 0, 0); run(3);
    curReq = "R8"; cfgWord = mkCfg(4, 1, 1, 0, 0, 0); run(9);

    cfgWord = mkCfg(1, 0, 0, 0, 0, 0);
    curReq = "R9";  clkCtrl = 2'b01; run(1);
    curReq = "R11"; clkCtrl = 2'b00; run(3);
    curReq = "R10"; clkCtrl = 2'b10; run(9);
    curReq = "R11"; clkCtrl = 2'b11; run(2);
    curReq = "R11"; clkCtrl = 2'b00; run(2);
    curReq = "R10"; clkCtrl = 2'b10; run(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired during %s actual=running expected=done", curReq);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule